// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block acts as the host side of an SMBus segment. It breaks one programmed transaction into an ordered series of byte-level bus events. Before starting a transaction, the controlling logic places the following on the setup inputs:

- a protocol code;
- an address/direction byte;
- a command byte;
- two data bytes;
- any block payload, loaded into the internal block buffer.

A one-cycle `go` pulse then launches the transaction. The sequencer walks the event pattern that the protocol requires, including the repeated start for reads that carry a command. It stores received bytes in its data registers or in the block buffer. At the end it raises a one-cycle `done` pulse together with an updated error flag.

The bus side is an abstract event channel, not bit-level SCL/SDA timing. The sequencer presents one event at a time and holds it until the bus agent pulses `busDone`. The event kinds are start (with a 7-bit address and a direction), send byte, receive byte, NACK and stop. For start events the agent also reports whether a target acknowledged.

Top module: `smbus_host_seq`

## Requirements
- R1: A `go` pulse while idle latches all setup inputs. Protocol codes 0, 1, 2, 3 and 5 are accepted. Any other code produces no bus event and finishes with `done` high and `err` set on the next clock edge.
- R2: Bit 0 of `addrDir` is the direction (1 = read) and bits 7:1 are the target address. Protocol 0 issues start (carrying that direction) and then stop, with no data bytes.
- R3: Protocol 1 with write issues start(write), send of the command byte, then stop. With read it issues start(read) and one receive into `data0Q`, then NACK and stop.
- R4: Protocol 2 write sends the command byte and then `data0`. Protocol 2 read issues start(write), sends the command, issues start(read), receives one byte into `data0Q`, then NACK and stop.
- R5: Protocol 3 write sends the command, then `data0` (low byte), then `data1` (high byte). Protocol 3 read uses the repeated-start pattern of R4 and receives two bytes: the first goes to `data0Q`, the second to `data1Q`.
- R6: Protocol 5 write sends the command, then a length byte equal to `data0` capped at 32, then that many buffer bytes starting at entry 0.
- R7: Protocol 5 read uses the repeated-start pattern of R4. The first received byte is the length; a value above 32 becomes 0. Exactly that many further bytes are received into buffer entries 0 upward. `data0Q` returns the clamped length.
- R8: A start event whose `busAck` is low is followed directly by a stop. The transaction then ends with `err` high.
- R9: `busy` is high from the accepted `go` until the stop event completes. While busy, `go` pulses and buffer writes are ignored.
- R10: After reset, `busy`, `done`, `err`, `evValid`, `data0Q` and `data1Q` are 0. `done` is a one-cycle pulse in the cycle after the stop event completes, and `err` changes only together with `done`.
- R11: The event kind, address, direction and byte are held stable while `evValid` is high and `busDone` has not arrived.
- R12: Event kinds on `evKind` are encoded as follows: 0 start, 1 send, 2 receive, 3 NACK, 4 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Launch pulse for one transaction |
| protoSel | input | 3 | Protocol code |
| addrDir | input | 8 | Target address in bits 7:1, direction in bit 0 |
| cmdByte | input | 8 | Command byte |
| data0In | input | 8 | First data byte / block write length |
| data1In | input | 8 | Second data byte |
| bufWrEn | input | 1 | Block buffer write strobe (idle only) |
| bufWrIdx | input | 5 | Block buffer write index |
| bufWrData | input | 8 | Block buffer write data |
| bufRdIdx | input | 5 | Block buffer read index |
| bufRdData | output | 8 | Block buffer entry at bufRdIdx |
| data0Q | output | 8 | Data register 0 |
| data1Q | output | 8 | Data register 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Error status of last transaction |
| evValid | output | 1 | Bus event presented |
| evKind | output | 3 | Bus event kind |
| evAddr | output | 7 | Target address for start events |
| evRead | output | 1 | Direction for start events |
| evByte | output | 8 | Byte for send events |
| busDone | input | 1 | Bus agent completed the current event |
| busAck | input | 1 | Target acknowledged (start events) |
| rxByte | input | 8 | Received byte (receive events) |

## Verification
The bench's bus agent completes each event one cycle after it appears. A new event is therefore presented on the edge that consumes the previous completion, and `done` rises on the following edge. Rather than count cycles ahead, the bench logs every event at the falling edge where it completes it. It waits, also on falling edges, for the `done` pulse, bounded by a timeout. At that same falling edge it compares the data registers, `err` and the event log against the expected values. It also checks that `done` and `busy` are low one falling edge later. Buffer contents are read through the combinational read port once the transaction has finished.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  localparam logic [2:0] EV_START = 3'd0;
  localparam logic [2:0] EV_SEND  = 3'd1;
  localparam logic [2:0] EV_RECV  = 3'd2;
  localparam logic [2:0] EV_NACK  = 3'd3;
  localparam logic [2:0] EV_STOP  = 3'd4;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  typedef struct packed {
    logic latch;
    logic txAdv;
    logic rxStore;
    logic clrIdx;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_SEND, ST_RESTART, ST_RECV, ST_NACK, ST_STOP
  } seqState_e;

endpackage

// File: rtl/smbus_seq_dp.sv
module smbus_seq_dp
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int IDX_W = $clog2(MAX_BLOCK + 3),
  parameter int BUF_AW = $clog2(MAX_BLOCK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  input  logic [2:0]        protoIn,
  input  logic [7:0]        addrDirIn,
  input  logic [7:0]        cmdIn,
  input  logic [7:0]        data0In,
  input  logic [7:0]        data1In,
  input  logic              bufWrEn,
  input  logic [BUF_AW-1:0] bufWrIdx,
  input  logic [7:0]        bufWrData,
  input  logic [BUF_AW-1:0] bufRdIdx,
  input  logic [7:0]        rxByte,
  output logic [7:0]        bufRdData,
  output logic [2:0]        protoQ,
  output logic [6:0]        addrQ,
  output logic              rdQ,
  output logic [7:0]        txByte,
  output logic              txLast,
  output logic              rxLast,
  output logic [7:0]        data0Q,
  output logic [7:0]        data1Q
);

  localparam logic [7:0] MAX_LEN = 8'(MAX_BLOCK);

  logic [7:0]       cmdQ;
  logic [7:0]       rxLen;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idxM1;
  logic [IDX_W-1:0] idxM2;
  logic [7:0]       idx8;
  logic [7:0]       wrLen;
  logic [7:0]       rxClamp;
  logic [7:0]       bufMem [MAX_BLOCK];
  logic [MAX_BLOCK-1:0] wrHit;

  assign idxM1   = idx - IDX_W'(1);
  assign idxM2   = idx - IDX_W'(2);
  assign idx8    = 8'(idx);
  assign wrLen   = (data0Q > MAX_LEN) ? MAX_LEN : data0Q;
  assign rxClamp = (rxByte > MAX_LEN) ? 8'd0 : rxByte;
  assign bufRdData = bufMem[bufRdIdx];

  // per-entry write select: idle loads from outside, busy loads from the bus
  for (genvar g = 0; g < MAX_BLOCK; g++) begin : gBufSel
    assign wrHit[g] = (!busy && bufWrEn && bufWrIdx == BUF_AW'(g)) ||
                      (strobe.rxStore && protoQ == PR_BLOCK && idx != '0 &&
                       idxM1 == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_BLOCK; i++) begin
      if (!rstN) bufMem[i] <= '0;
      else if (wrHit[i]) bufMem[i] <= strobe.rxStore ? rxByte : bufWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoQ <= '0;
      addrQ  <= '0;
      rdQ    <= 1'b0;
      cmdQ   <= '0;
      data0Q <= '0;
      data1Q <= '0;
      rxLen  <= '0;
      idx    <= '0;
    end else if (strobe.latch) begin
      protoQ <= protoIn;
      addrQ  <= addrDirIn[7:1];
      rdQ    <= addrDirIn[0];
      cmdQ   <= cmdIn;
      data0Q <= data0In;
      data1Q <= data1In;
      idx    <= '0;
    end else begin
      if (strobe.clrIdx) idx <= '0;
      else if (strobe.txAdv || strobe.rxStore) idx <= idx + IDX_W'(1);
      if (strobe.rxStore) begin
        unique case (protoQ)
          PR_WORD: begin
            if (idx == '0) data0Q <= rxByte;
            else data1Q <= rxByte;
          end
          PR_BLOCK: begin
            if (idx == '0) begin
              data0Q <= rxClamp;
              rxLen  <= rxClamp;
            end
          end
          default: data0Q <= rxByte;
        endcase
      end
    end
  end

  always_comb begin
    txByte = cmdQ;
    if (idx != '0) begin
      unique case (protoQ)
        PR_BDATA: txByte = data0Q;
        PR_WORD:  txByte = (idx == IDX_W'(1)) ? data0Q : data1Q;
        PR_BLOCK: txByte = (idx == IDX_W'(1)) ? wrLen : bufMem[idxM2[BUF_AW-1:0]];
        default:  txByte = cmdQ;
      endcase
    end
  end

  always_comb begin
    unique case (protoQ)
      PR_BDATA: txLast = rdQ ? (idx == '0) : (idx == IDX_W'(1));
      PR_WORD:  txLast = rdQ ? (idx == '0) : (idx == IDX_W'(2));
      PR_BLOCK: txLast = rdQ ? (idx == '0) : (idx8 == wrLen + 8'd1);
      default:  txLast = 1'b1;
    endcase
  end

  always_comb begin
    unique case (protoQ)
      PR_WORD:  rxLast = (idx == IDX_W'(1));
      PR_BLOCK: rxLast = (idx == '0) ? (rxClamp == 8'd0) : (idx8 == rxLen);
      default:  rxLast = 1'b1;
    endcase
  end

endmodule

// File: rtl/smbus_seq_ctl.sv
module smbus_seq_ctl
  import smbus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic [2:0] protoIn,
  input  logic [2:0] protoQ,
  input  logic       rdQ,
  input  logic       txLast,
  input  logic       rxLast,
  input  logic       busDone,
  input  logic       busAck,
  output seqStrobe_t strobe,
  output logic       evValid,
  output logic [2:0] evKind,
  output logic       evRead,
  output logic       busy,
  output logic       done,
  output logic       err
);

  seqState_e state, stateNxt;
  logic errAcc, errSet, doneSet, protoOk;

  assign protoOk = protoIn inside {PR_QUICK, PR_BYTE, PR_BDATA, PR_WORD, PR_BLOCK};
  assign busy    = (state != ST_IDLE);
  assign evValid = busy;

  always_comb begin
    unique case (state)
      ST_SEND:    evKind = EV_SEND;
      ST_RECV:    evKind = EV_RECV;
      ST_NACK:    evKind = EV_NACK;
      ST_STOP:    evKind = EV_STOP;
      default:    evKind = EV_START;
    endcase
    if (state == ST_RESTART) evRead = 1'b1;
    else if (state == ST_START) evRead = (protoQ == PR_QUICK || protoQ == PR_BYTE) ? rdQ : 1'b0;
    else evRead = 1'b0;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    errSet   = 1'b0;
    doneSet  = 1'b0;
    unique case (state)
      ST_IDLE: if (go) begin
        strobe.latch = 1'b1;
        if (protoOk) stateNxt = ST_START;
        else begin
          errSet  = 1'b1;
          doneSet = 1'b1;
        end
      end
      ST_START: if (busDone) begin
        if (!busAck) begin
          errSet   = 1'b1;
          stateNxt = ST_STOP;
        end else if (protoQ == PR_QUICK) stateNxt = ST_STOP;
        else if (protoQ == PR_BYTE && rdQ) stateNxt = ST_RECV;
        else stateNxt = ST_SEND;
      end
      ST_SEND: if (busDone) begin
        strobe.txAdv = 1'b1;
        if (txLast) begin
          if (rdQ) begin
            strobe.clrIdx = 1'b1;
            stateNxt = ST_RESTART;
          end else stateNxt = ST_STOP;
        end
      end
      ST_RESTART: if (busDone) begin
        if (!busAck) begin
          errSet   = 1'b1;
          stateNxt = ST_STOP;
        end else stateNxt = ST_RECV;
      end
      ST_RECV: if (busDone) begin
        strobe.rxStore = 1'b1;
        if (rxLast) stateNxt = ST_NACK;
      end
      ST_NACK: if (busDone) stateNxt = ST_STOP;
      ST_STOP: if (busDone) begin
        doneSet  = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errAcc <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneSet;
      if (strobe.latch) errAcc <= 1'b0;
      else if (errSet) errAcc <= 1'b1;
      if (doneSet) err <= errAcc | errSet;
    end
  end

endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int BUF_AW = $clog2(MAX_BLOCK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [2:0]        protoSel,
  input  logic [7:0]        addrDir,
  input  logic [7:0]        cmdByte,
  input  logic [7:0]        data0In,
  input  logic [7:0]        data1In,
  input  logic              bufWrEn,
  input  logic [BUF_AW-1:0] bufWrIdx,
  input  logic [7:0]        bufWrData,
  input  logic [BUF_AW-1:0] bufRdIdx,
  output logic [7:0]        bufRdData,
  output logic [7:0]        data0Q,
  output logic [7:0]        data1Q,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              evValid,
  output logic [2:0]        evKind,
  output logic [6:0]        evAddr,
  output logic              evRead,
  output logic [7:0]        evByte,
  input  logic              busDone,
  input  logic              busAck,
  input  logic [7:0]        rxByte
);

  seqStrobe_t strobe;
  logic [2:0] protoQ;
  logic       rdQ, txLast, rxLast;

  smbus_seq_ctl ctl_i (
    .clk(clk), .rstN(rstN), .go(go), .protoIn(protoSel), .protoQ(protoQ),
    .rdQ(rdQ), .txLast(txLast), .rxLast(rxLast), .busDone(busDone),
    .busAck(busAck), .strobe(strobe), .evValid(evValid), .evKind(evKind),
    .evRead(evRead), .busy(busy), .done(done), .err(err)
  );

  smbus_seq_dp #(.MAX_BLOCK(MAX_BLOCK)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .protoIn(protoSel),
    .addrDirIn(addrDir), .cmdIn(cmdByte), .data0In(data0In), .data1In(data1In),
    .bufWrEn(bufWrEn), .bufWrIdx(bufWrIdx), .bufWrData(bufWrData),
    .bufRdIdx(bufRdIdx), .rxByte(rxByte), .bufRdData(bufRdData),
    .protoQ(protoQ), .addrQ(evAddr), .rdQ(rdQ), .txByte(evByte),
    .txLast(txLast), .rxLast(rxLast), .data0Q(data0Q), .data1Q(data1Q)
  );

endmodule

// File: rtl/smbus_host_seq_chk.sv
module smbus_host_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       evValid,
  input logic [2:0] evKind,
  input logic [6:0] evAddr,
  input logic       evRead,
  input logic [7:0] evByte,
  input logic       busDone
);

  // R11
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && !busDone |=> evValid && $stable(evKind) && $stable(evAddr) &&
    $stable(evRead) && $stable(evByte));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !evValid);

  // R9
  ev_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> busy);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(err) |-> done);

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && evKind == 3'd4 && busDone |=> done && !busy);

  // R12
  kind_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> evKind <= 3'd4);

endmodule

bind smbus_host_seq smbus_host_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .evValid(evValid), .evKind(evKind), .evAddr(evAddr), .evRead(evRead),
  .evByte(evByte), .busDone(busDone)
);

// File: tb/smbus_host_seq_tb.sv
module smbus_host_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_MAX = 8192;
  localparam logic [6:0] TGT = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic go = 1'b0;
  logic [2:0] protoSel = '0;
  logic [7:0] addrDir = '0, cmdByte = '0, data0In = '0, data1In = '0;
  logic bufWrEn = 1'b0;
  logic [4:0] bufWrIdx = '0, bufRdIdx = '0;
  logic [7:0] bufWrData = '0;
  logic [7:0] bufRdData, data0Q, data1Q;
  logic busy, done, err, evValid, evRead;
  logic [2:0] evKind;
  logic [6:0] evAddr;
  logic [7:0] evByte;
  logic busDone = 1'b0, busAck = 1'b0;
  logic [7:0] rxByte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_host_seq dut_i (
    .clk(clk), .rstN(rstN), .go(go), .protoSel(protoSel), .addrDir(addrDir),
    .cmdByte(cmdByte), .data0In(data0In), .data1In(data1In), .bufWrEn(bufWrEn),
    .bufWrIdx(bufWrIdx), .bufWrData(bufWrData), .bufRdIdx(bufRdIdx),
    .bufRdData(bufRdData), .data0Q(data0Q), .data1Q(data1Q), .busy(busy),
    .done(done), .err(err), .evValid(evValid), .evKind(evKind), .evAddr(evAddr),
    .evRead(evRead), .evByte(evByte), .busDone(busDone), .busAck(busAck),
    .rxByte(rxByte)
  );

  int checks = 0, failures = 0;

  // bus agent log and receive script
  logic [2:0] logKind [LOG_MAX];
  logic [6:0] logAddr [LOG_MAX];
  logic       logRd   [LOG_MAX];
  logic [7:0] logByte [LOG_MAX];
  int logN = 0;
  logic [7:0] script [LOG_MAX];
  int rxPtr = 0;

  always @(negedge clk) begin
    if (!rstN) busDone = 1'b0;
    else if (evValid && !busDone) begin
      busDone = 1'b1;
      busAck  = (evKind != 3'd0) || (evAddr == TGT);
      if (evKind == 3'd2) begin
        rxByte = script[rxPtr % LOG_MAX];
        rxPtr++;
      end
      logKind[logN % LOG_MAX] = evKind;
      logAddr[logN % LOG_MAX] = evAddr;
      logRd[logN % LOG_MAX]   = evRead;
      logByte[logN % LOG_MAX] = evByte;
      logN++;
    end else busDone = 1'b0;
  end

  // expected model
  logic [2:0] eKind [64];
  logic [6:0] eAddr [64];
  logic       eRd   [64];
  logic [7:0] eByte [64];
  int eN;
  logic [7:0] mD0, mD1;
  logic       mErr;
  logic [7:0] mBuf [32];

  function automatic void addEv(logic [2:0] k, logic [6:0] a, logic r, logic [7:0] b);
    eKind[eN] = k; eAddr[eN] = a; eRd[eN] = r; eByte[eN] = b; eN++;
  endfunction

  function automatic int clampW(logic [7:0] v);
    return (v > 8'd32) ? 32 : int'(v);
  endfunction

  function automatic void buildExp(logic [2:0] p, logic [7:0] ad, logic [7:0] c,
                                   logic [7:0] d0, logic [7:0] d1, int sBase);
    logic [6:0] a = ad[7:1];
    logic rd = ad[0];
    logic ack = (a == TGT);
    int n;
    eN = 0; mD0 = d0; mD1 = d1; mErr = 1'b0;
    if (!(p inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5})) begin
      mErr = 1'b1;
      return;
    end
    addEv(3'd0, a, (p <= 3'd1) ? rd : 1'b0, 8'h00);
    if (!ack) begin
      addEv(3'd4, a, 1'b0, 8'h00);
      mErr = 1'b1;
      return;
    end
    if (p == 3'd1 && rd) begin
      addEv(3'd2, a, 1'b0, 8'h00);
      mD0 = script[sBase % LOG_MAX];
    end else if (p != 3'd0) begin
      addEv(3'd1, a, 1'b0, c);
      if (!rd || p == 3'd1) begin
        if (p == 3'd2) addEv(3'd1, a, 1'b0, d0);
        if (p == 3'd3) begin
          addEv(3'd1, a, 1'b0, d0);
          addEv(3'd1, a, 1'b0, d1);
        end
        if (p == 3'd5) begin
          n = clampW(d0);
          addEv(3'd1, a, 1'b0, 8'(n));
          for (int i = 0; i < n; i++) addEv(3'd1, a, 1'b0, mBuf[i]);
        end
      end else begin
        addEv(3'd0, a, 1'b1, 8'h00);
        addEv(3'd2, a, 1'b0, 8'h00);
        mD0 = script[sBase % LOG_MAX];
        if (p == 3'd3) begin
          addEv(3'd2, a, 1'b0, 8'h00);
          mD1 = script[(sBase + 1) % LOG_MAX];
        end
        if (p == 3'd5) begin
          n = (script[sBase % LOG_MAX] > 8'd32) ? 0 : int'(script[sBase % LOG_MAX]);
          mD0 = 8'(n);
          for (int i = 0; i < n; i++) begin
            addEv(3'd2, a, 1'b0, 8'h00);
            mBuf[i] = script[(sBase + 1 + i) % LOG_MAX];
          end
        end
      end
    end
    if (rd && p != 3'd0) addEv(3'd3, a, 1'b0, 8'h00);
    addEv(3'd4, a, 1'b0, 8'h00);
  endfunction

  function automatic string reqOf(logic [2:0] p, logic ack);
    if (!ack && p inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5}) return "R8";
    case (p)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd5: return "R6/R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseGo(logic [2:0] p, logic [7:0] ad, logic [7:0] c,
                         logic [7:0] d0, logic [7:0] d1);
    protoSel = p; addrDir = ad; cmdByte = c; data0In = d0; data1In = d1;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    int cnt = 0;
    seen = 1'b0;
    while (cnt < 500) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic compareRun(string req, int lBase);
    bit mism = 1'b0;
    int got = logN - lBase;
    check(got == eN, req, "event count", got, eN);
    if (got == eN) begin
      for (int i = 0; i < eN; i++) begin
        int j = (lBase + i) % LOG_MAX;
        if (logKind[j] != eKind[i]) mism = 1'b1;
        if (eKind[i] == 3'd0 && (logAddr[j] != eAddr[i] || logRd[j] != eRd[i])) mism = 1'b1;
        if (eKind[i] == 3'd1 && logByte[j] != eByte[i]) mism = 1'b1;
      end
      check(!mism, req, "event sequence", int'(mism), 0);
    end
    check(data0Q == mD0, req, "data0Q", data0Q, mD0);
    check(data1Q == mD1, req, "data1Q", data1Q, mD1);
    check(err == mErr, req, "err", err, mErr);
  endtask

  task automatic runTx(logic [2:0] p, logic [7:0] ad, logic [7:0] c,
                       logic [7:0] d0, logic [7:0] d1);
    int lBase = logN;
    bit seen;
    string req = reqOf(p, ad[7:1] == TGT);
    buildExp(p, ad, c, d0, d1, rxPtr);
    pulseGo(p, ad, c, d0, d1);
    waitDone(seen);
    check(seen, req, "done seen", int'(seen), 1);
    if (!seen) return;
    compareRun(req, lBase);
    if (p == 3'd5 && ad[0]) begin
      for (int i = 0; i < 32; i++) begin
        bufRdIdx = 5'(i);
        #1;
        check(bufRdData == mBuf[i], "R7", "buffer entry", bufRdData, mBuf[i]);
      end
    end
    @(negedge clk);
    check(!done && !busy, "R10", "done pulse ends", int'(done), 0);
  endtask

  task automatic loadBuf(int seedOfs);
    for (int i = 0; i < 32; i++) begin
      mBuf[i] = 8'($urandom) ^ 8'(seedOfs);
      bufWrEn = 1'b1; bufWrIdx = 5'(i); bufWrData = mBuf[i];
      @(negedge clk);
    end
    bufWrEn = 1'b0;
  endtask

  task automatic fillScript(int n, logic [7:0] first);
    script[rxPtr % LOG_MAX] = first;
    for (int i = 1; i < n; i++) script[(rxPtr + i) % LOG_MAX] = 8'($urandom);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] keepB0;
    int lBase;
    bit seen;
    void'($urandom(32'd2718));
    for (int i = 0; i < 32; i++) mBuf[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !err && !evValid, "R10", "reset flags",
          {busy, done, err, evValid}, 0);
    check(data0Q == 0 && data1Q == 0, "R10", "reset data", {data0Q, data1Q}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed cases
    runTx(3'd0, {TGT, 1'b1}, 8'h11, 8'h01, 8'h02);           // R2 quick read
    runTx(3'd0, {TGT, 1'b0}, 8'h11, 8'h03, 8'h04);           // R2 quick write
    runTx(3'd1, {TGT, 1'b0}, 8'hA5, 8'h00, 8'h00);           // R3 send
    fillScript(1, 8'h5C);
    runTx(3'd1, {TGT, 1'b1}, 8'h00, 8'h00, 8'h00);           // R3 receive
    runTx(3'd2, {TGT, 1'b0}, 8'h20, 8'h9E, 8'h00);           // R4
    fillScript(1, 8'h3D);
    runTx(3'd2, {TGT, 1'b1}, 8'h21, 8'h00, 8'h00);           // R4
    runTx(3'd3, {TGT, 1'b0}, 8'h30, 8'h34, 8'h12);           // R5
    fillScript(2, 8'hCD);
    runTx(3'd3, {TGT, 1'b1}, 8'h31, 8'h00, 8'h00);           // R5
    loadBuf(1);
    runTx(3'd5, {TGT, 1'b0}, 8'h40, 8'd45, 8'h00);           // R6 clamp to 32
    runTx(3'd5, {TGT, 1'b0}, 8'h41, 8'd0, 8'h00);            // R6 zero length
    fillScript(34, 8'd32);
    runTx(3'd5, {TGT, 1'b1}, 8'h42, 8'h00, 8'h00);           // R7 full block
    fillScript(34, 8'd33);
    runTx(3'd5, {TGT, 1'b1}, 8'h43, 8'h00, 8'h00);           // R7 clamp to 0
    runTx(3'd4, {TGT, 1'b0}, 8'h00, 8'h00, 8'h00);           // R1 invalid
    runTx(3'd7, {TGT, 1'b1}, 8'h00, 8'h00, 8'h00);           // R1 invalid
    runTx(3'd3, {7'h13, 1'b1}, 8'h50, 8'h00, 8'h00);         // R8 no ack
    runTx(3'd0, {7'h13, 1'b0}, 8'h50, 8'h00, 8'h00);         // R8 no ack
    runTx(3'd0, {TGT, 1'b0}, 8'h00, 8'h00, 8'h00);           // R10 err clears

    // R9: go and buffer writes ignored while busy
    bufRdIdx = 5'd0;
    #1 keepB0 = bufRdData;
    fillScript(2, 8'h77);
    lBase = logN;
    buildExp(3'd3, {TGT, 1'b1}, 8'h60, 8'h00, 8'h00, rxPtr);
    pulseGo(3'd3, {TGT, 1'b1}, 8'h60, 8'h00, 8'h00);
    repeat (2) @(negedge clk);
    check(busy, "R9", "busy during transaction", int'(busy), 1);
    bufWrEn = 1'b1; bufWrIdx = 5'd0; bufWrData = ~keepB0;
    pulseGo(3'd0, {TGT, 1'b0}, 8'hFF, 8'hEE, 8'hDD);
    bufWrEn = 1'b0;
    waitDone(seen);
    check(seen, "R9", "done seen", int'(seen), 1);
    compareRun("R9", lBase);
    bufRdIdx = 5'd0;
    #1 check(bufRdData == keepB0, "R9", "buffer untouched", bufRdData, keepB0);
    @(negedge clk);

    // constrained random mix
    for (int t = 0; t < 60; t++) begin
      logic [2:0] p;
      logic [7:0] ad;
      int sel = $urandom_range(0, 7);
      p = (sel == 4) ? 3'd5 : (sel == 6) ? 3'd6 : 3'(sel);
      ad = {($urandom_range(0, 5) == 0) ? 7'h55 : TGT, 1'($urandom)};
      if (p == 3'd5 && !ad[0]) loadBuf(t);
      fillScript(40, 8'($urandom_range(0, 40)));
      runTx(p, ad, 8'($urandom), 8'($urandom_range(0, 40)), 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule